// File: doc/BRIEF.md
# Floating-Point Adder/Subtractor

This block adds or subtracts two binary floating-point operands in the IEEE-754 interchange layout. By default they are 64 bits wide, with an 11-bit exponent and a 52-bit fraction. The exponent and fraction widths are parameters, so the same datapath also builds narrow formats. A select input turns the operation into subtraction by flipping the sign of the second operand. A 2-bit code picks one of the four directed or nearest rounding rules.

The datapath runs in this order:
- order the operands by magnitude;
- shift the smaller significand right, keeping guard, round and sticky bits;
- add or subtract the magnitudes;
- normalize the raw sum (a right shift by one on carry, or a left shift limited so the exponent stays at or above the smallest normal value);
- round;
- renormalize if the rounding carries.

Zero, infinity and NaN operands take a separate path. Subnormal operands carry an effective exponent of 1 and no hidden bit. The result and four status flags are captured in one output register when the enable strobe is high.

Top module: `fp_addsub`

## Requirements
- R1: Operands and result use this layout: sign in the top bit, then an EXP_W-bit exponent biased by 2^(EXP_W-1)-1, then an FRAC_W-bit fraction. A nonzero exponent below all-ones adds a hidden leading 1. Exponent 0 means (0.F)×2^(1-bias). For finite operands the result is the exact sum, rounded once.
- R2: With sub_i=0 the block computes a+b. With sub_i=1 it computes a-b, which is a plus b with b's sign bit inverted.
- R3: rmode_i selects rounding: 00 nearest with ties to even, 01 toward zero, 10 toward +infinity, 11 toward -infinity. A rounding carry out of the significand raises the exponent by one.
- R4: When the exponents are far apart, the smaller operand affects only the rounding of the larger one.
- R5: An exact-zero sum of operands with opposite signs is +0, or -0 when rmode_i=11. Two zeros of the same sign keep that sign.
- R6: If the rounded exponent reaches all-ones, overflow_o and inexact_o are raised. The result is infinity for nearest rounding, and for directed rounding away from zero in the result's direction. Otherwise it is the largest finite value of the result's sign.
- R7: A NaN operand, or infinities of opposite effective sign, gives the quiet NaN (sign 0, exponent all-ones, only the fraction MSB set) with invalid_o=1 and no other flag.
- R8: Otherwise an infinite operand gives infinity with that operand's effective sign, and no flags.
- R9: inexact_o is 1 exactly when the rounded result differs from the exact sum.
- R10: underflow_o is 1 exactly when the result is a nonzero subnormal (exponent field 0, fraction nonzero).
- R11: The result and flags appear after the rising edge at which en is sampled high. They hold while en is low.
- R12: Synchronous active-low reset clears the result and all four flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Capture strobe for the operation |
| a_i | input | 1+EXP_W+FRAC_W | First operand |
| b_i | input | 1+EXP_W+FRAC_W | Second operand |
| sub_i | input | 1 | 0 adds, 1 subtracts |
| rmode_i | input | 2 | Rounding rule code |
| sum_o | output | 1+EXP_W+FRAC_W | Registered result |
| overflow_o | output | 1 | Result exceeded the finite range |
| underflow_o | output | 1 | Result is a nonzero subnormal |
| inexact_o | output | 1 | Result was rounded |
| invalid_o | output | 1 | Result is the quiet NaN from an invalid operation |

## Verification
Several cases are rare among random 64-bit operands:
- ties in nearest-even rounding;
- carries out of rounding that push the result into overflow;
- cancellation down to a subnormal;
- sticky bits that decide directed rounding after a subtraction.

To reach all of them, the bench builds a second instance with a 3-bit exponent and a 3-bit fraction. It sweeps every operand pair under every rounding code and both operations. Each result is compared against an integer model that forms the exact sum on a common grid and rounds it. A handful of directed 64-bit vectors then confirm that the default widths wire up the same way.

// File: rtl/fpadd_pkg.sv
// Shared types for the floating-point adder/subtractor.
// Assumes: the rounding code values are fixed by the interface contract.
package fpadd_pkg;

    typedef enum logic [1:0] {
        RND_NEAR_EVEN = 2'b00,
        RND_TO_ZERO   = 2'b01,
        RND_TO_POS    = 2'b10,
        RND_TO_NEG    = 2'b11
    } rnd_mode_e;

    typedef enum logic [1:0] {
        CLS_FINITE = 2'd0,
        CLS_INF    = 2'd1,
        CLS_NAN    = 2'd2
    } op_class_e;

endpackage

// File: rtl/fpa_unpack.sv
// Splits one packed operand into sign, effective exponent, significand
// with the hidden bit, and a class (finite, infinite, NaN).
// Assumes: subnormals and zero use effective exponent 1 and no hidden bit.
module fpa_unpack
    import fpadd_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52
) (
    input  logic [EXP_W+FRAC_W:0] op_i,
    output logic                  sign_o,
    output logic [EXP_W-1:0]      exp_o,
    output logic [FRAC_W:0]       sig_o,
    output op_class_e             cls_o
);
    localparam int N_W = 1 + EXP_W + FRAC_W;

    logic [EXP_W-1:0]  exp_raw;
    logic [FRAC_W-1:0] frac_raw;
    logic              exp_zero;

    // Field extraction and classification of the operand.
    always_comb begin
        exp_raw  = op_i[N_W-2:FRAC_W];
        frac_raw = op_i[FRAC_W-1:0];
        exp_zero = ~|exp_raw;
        sign_o   = op_i[N_W-1];
        exp_o    = exp_zero ? EXP_W'(1) : exp_raw;
        sig_o    = {~exp_zero, frac_raw};
        if (&exp_raw) cls_o = (|frac_raw) ? CLS_NAN : CLS_INF;
        else          cls_o = CLS_FINITE;
    end

endmodule

// File: rtl/fpa_align.sv
// Orders two finite operands by magnitude, aligns the smaller significand
// with guard, round and sticky bits, and adds or subtracts the magnitudes.
// Assumes: the second operand's sign already reflects subtraction.
module fpa_align #(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52
) (
    input  logic               sign_a_i,
    input  logic [EXP_W-1:0]   exp_a_i,
    input  logic [FRAC_W:0]    sig_a_i,
    input  logic               sign_b_i,
    input  logic [EXP_W-1:0]   exp_b_i,
    input  logic [FRAC_W:0]    sig_b_i,
    output logic               sign_o,
    output logic [EXP_W-1:0]   exp_o,
    output logic [FRAC_W+4:0]  sum_o
);
    localparam int SIG_W = FRAC_W + 1;
    localparam int W     = SIG_W + 3;   // significand plus guard, round, sticky

    logic               a_first;
    logic [EXP_W-1:0]   exp_small;
    logic [SIG_W-1:0]   sig_big, sig_small;
    logic [EXP_W-1:0]   diff;
    logic [2*W-1:0]     wide;
    logic [W-1:0]       shifted, big_al, small_al;
    logic               sticky;
    logic               eff_sub;

    // Magnitude ordering so that a subtraction never goes negative.
    always_comb begin
        a_first   = {exp_a_i, sig_a_i} >= {exp_b_i, sig_b_i};
        sign_o    = a_first ? sign_a_i : sign_b_i;
        exp_o     = a_first ? exp_a_i  : exp_b_i;
        exp_small = a_first ? exp_b_i  : exp_a_i;
        sig_big   = a_first ? sig_a_i  : sig_b_i;
        sig_small = a_first ? sig_b_i  : sig_a_i;
        diff      = exp_o - exp_small;
    end

    // Right shift of the smaller significand with sticky collection.
    always_comb begin
        wide = {sig_small, 3'b000, {W{1'b0}}} >> diff;
        if (int'(diff) >= W) begin
            shifted = '0;
            sticky  = |sig_small;
        end else begin
            shifted = wide[2*W-1:W];
            sticky  = |wide[W-1:0];
        end
        small_al = shifted | {{(W-1){1'b0}}, sticky};
        big_al   = {sig_big, 3'b000};
    end

    // Signed-magnitude add: one extra bit catches the carry.
    always_comb begin
        eff_sub = sign_a_i ^ sign_b_i;
        if (eff_sub) sum_o = {1'b0, big_al} - {1'b0, small_al};
        else         sum_o = {1'b0, big_al} + {1'b0, small_al};
    end

endmodule

// File: rtl/fpa_normround.sv
// Normalizes the raw magnitude sum, rounds it by the selected rule,
// renormalizes on a rounding carry and packs the finite result with flags.
// Assumes: sum_i holds significand, guard, round, sticky and a carry bit.
module fpa_normround
    import fpadd_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52
) (
    input  logic [FRAC_W+4:0]     sum_i,
    input  logic [EXP_W-1:0]      exp_i,
    input  logic                  sign_i,
    input  logic                  zero_sign_i,
    input  rnd_mode_e             rmode_i,
    output logic [EXP_W+FRAC_W:0] res_o,
    output logic                  ovf_o,
    output logic                  unf_o,
    output logic                  inx_o
);
    localparam int SIG_W = FRAC_W + 1;
    localparam int W     = SIG_W + 3;
    localparam int LZW   = $clog2(W + 1);
    localparam int XE    = EXP_W + 2;
    localparam int EMAX  = (1 << EXP_W) - 1;

    logic [LZW-1:0]    lz;
    logic [XE-1:0]     lim, shl, e1, e2;
    logic [W-1:0]      norm;
    logic [SIG_W-1:0]  keep;
    logic              g_bit, st_bit, inc, to_inf;
    logic [SIG_W:0]    rnd;
    logic [FRAC_W-1:0] frac;

    // Leading-zero count below the carry bit.
    always_comb begin
        lz = LZW'(W);
        for (int i = 0; i < W; i++) begin
            if (sum_i[i]) lz = LZW'(W - 1 - i);
        end
    end

    // Normalize: right by one on carry, else left but not below exponent 1.
    always_comb begin
        lim = XE'(exp_i) - XE'(1);
        shl = '0;
        if (sum_i[W]) begin
            norm = sum_i[W:1] | {{(W-1){1'b0}}, sum_i[0]};
            e1   = XE'(exp_i) + XE'(1);
        end else begin
            shl  = (XE'(lz) < lim) ? XE'(lz) : lim;
            norm = sum_i[W-1:0] << shl;
            e1   = XE'(exp_i) - shl;
        end
    end

    // Round by the selected rule and renormalize on a carry out.
    always_comb begin
        keep   = norm[W-1:3];
        g_bit  = norm[2];
        st_bit = norm[1] | norm[0];
        case (rmode_i)
            RND_NEAR_EVEN: inc = g_bit & (st_bit | keep[0]);
            RND_TO_ZERO:   inc = 1'b0;
            RND_TO_POS:    inc = (g_bit | st_bit) & ~sign_i;
            default:       inc = (g_bit | st_bit) & sign_i;
        endcase
        rnd = {1'b0, keep} + (SIG_W+1)'(inc);
        if (rnd[SIG_W]) begin
            frac = '0;
            e2   = e1 + XE'(1);
        end else begin
            frac = rnd[FRAC_W-1:0];
            e2   = rnd[FRAC_W] ? e1 : '0;
        end
    end

    // Pack the result and derive the status flags.
    always_comb begin
        to_inf = (rmode_i == RND_NEAR_EVEN) ||
                 ((rmode_i == RND_TO_POS) && !sign_i) ||
                 ((rmode_i == RND_TO_NEG) && sign_i);
        ovf_o = 1'b0;
        unf_o = 1'b0;
        inx_o = 1'b0;
        if (sum_i == '0) begin
            res_o = {zero_sign_i, {(EXP_W+FRAC_W){1'b0}}};
        end else if (e2 >= XE'(EMAX)) begin
            ovf_o = 1'b1;
            inx_o = 1'b1;
            res_o = to_inf ? {sign_i, {EXP_W{1'b1}}, {FRAC_W{1'b0}}}
                           : {sign_i, EXP_W'(EMAX - 1), {FRAC_W{1'b1}}};
        end else begin
            inx_o = g_bit | st_bit;
            unf_o = (e2 == '0) && (|frac);
            res_o = {sign_i, e2[EXP_W-1:0], frac};
        end
    end

endmodule

// File: rtl/fp_addsub.sv
// Floating-point adder/subtractor top: unpacks both operands, routes
// special values, runs the align and normalize/round stages, and registers
// the result with overflow, underflow, inexact and invalid flags.
// Assumes: one operation per enable strobe, result one edge later.
module fp_addsub
    import fpadd_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  en,
    input  logic [EXP_W+FRAC_W:0] a_i,
    input  logic [EXP_W+FRAC_W:0] b_i,
    input  logic                  sub_i,
    input  logic [1:0]            rmode_i,
    output logic [EXP_W+FRAC_W:0] sum_o,
    output logic                  overflow_o,
    output logic                  underflow_o,
    output logic                  inexact_o,
    output logic                  invalid_o
);
    localparam int N_W = 1 + EXP_W + FRAC_W;
    localparam logic [N_W-1:0] QNAN =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    rnd_mode_e                 rmode;
    logic [1:0][N_W-1:0]       ops;
    logic [1:0]                sgn;
    logic [1:0][EXP_W-1:0]     ex;
    logic [1:0][FRAC_W:0]      sg;
    op_class_e                 cls [2];

    logic                      al_sign;
    logic [EXP_W-1:0]          al_exp;
    logic [FRAC_W+4:0]         al_sum;
    logic                      zero_sign;
    logic [N_W-1:0]            fin_res;
    logic                      fin_ovf, fin_unf, fin_inx;
    logic [N_W-1:0]            nxt_res;
    logic                      nxt_ovf, nxt_unf, nxt_inx, nxt_inv;

    assign rmode  = rnd_mode_e'(rmode_i);
    assign ops[0] = a_i;
    assign ops[1] = {b_i[N_W-1] ^ sub_i, b_i[N_W-2:0]};

    for (genvar k = 0; k < 2; k++) begin : g_unpack
        fpa_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unpack (
            .op_i   (ops[k]),
            .sign_o (sgn[k]),
            .exp_o  (ex[k]),
            .sig_o  (sg[k]),
            .cls_o  (cls[k])
        );
    end

    fpa_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_align (
        .sign_a_i (sgn[0]),
        .exp_a_i  (ex[0]),
        .sig_a_i  (sg[0]),
        .sign_b_i (sgn[1]),
        .exp_b_i  (ex[1]),
        .sig_b_i  (sg[1]),
        .sign_o   (al_sign),
        .exp_o    (al_exp),
        .sum_o    (al_sum)
    );

    // Sign of an exact zero: shared sign if equal, else set by the mode.
    assign zero_sign = (sgn[0] == sgn[1]) ? sgn[0] : (rmode == RND_TO_NEG);

    fpa_normround #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_normround (
        .sum_i       (al_sum),
        .exp_i       (al_exp),
        .sign_i      (al_sign),
        .zero_sign_i (zero_sign),
        .rmode_i     (rmode),
        .res_o       (fin_res),
        .ovf_o       (fin_ovf),
        .unf_o       (fin_unf),
        .inx_o       (fin_inx)
    );

    // Special-value routing ahead of the output register.
    always_comb begin
        nxt_res = fin_res;
        nxt_ovf = fin_ovf;
        nxt_unf = fin_unf;
        nxt_inx = fin_inx;
        nxt_inv = 1'b0;
        if ((cls[0] == CLS_NAN) || (cls[1] == CLS_NAN) ||
            ((cls[0] == CLS_INF) && (cls[1] == CLS_INF) && (sgn[0] != sgn[1]))) begin
            nxt_res = QNAN;
            {nxt_ovf, nxt_unf, nxt_inx} = 3'b000;
            nxt_inv = 1'b1;
        end else if (cls[0] == CLS_INF) begin
            nxt_res = {sgn[0], {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
            {nxt_ovf, nxt_unf, nxt_inx} = 3'b000;
        end else if (cls[1] == CLS_INF) begin
            nxt_res = {sgn[1], {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
            {nxt_ovf, nxt_unf, nxt_inx} = 3'b000;
        end
    end

    // Output register: cleared by reset, loaded when enable is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_o       <= '0;
            overflow_o  <= 1'b0;
            underflow_o <= 1'b0;
            inexact_o   <= 1'b0;
            invalid_o   <= 1'b0;
        end else if (en) begin
            sum_o       <= nxt_res;
            overflow_o  <= nxt_ovf;
            underflow_o <= nxt_unf;
            inexact_o   <= nxt_inx;
            invalid_o   <= nxt_inv;
        end
    end

    AST_OVF_INEXACT: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_o |-> inexact_o && !invalid_o); // R6
    AST_INVALID_QNAN: assert property (@(posedge clk) disable iff (!rst_n)
        invalid_o |-> (sum_o == QNAN) && !overflow_o && !underflow_o); // R7
    AST_UNF_SUBNORMAL: assert property (@(posedge clk) disable iff (!rst_n)
        underflow_o |-> (sum_o[N_W-2:FRAC_W] == '0) && (sum_o[FRAC_W-1:0] != '0)); // R10
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable({sum_o, overflow_o, underflow_o, inexact_o, invalid_o})); // R11
    AST_CANCEL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        en && (cls[0] == CLS_FINITE) && (cls[1] == CLS_FINITE) &&
        (a_i[N_W-2:0] == b_i[N_W-2:0]) && (a_i[N_W-1] != (b_i[N_W-1] ^ sub_i))
        |=> (sum_o[N_W-2:0] == '0) && !inexact_o); // R5

endmodule

// File: tb/test_fp_addsub.sv
`timescale 1ns/1ps
module test_fp_addsub;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Default 64-bit instance.
    logic        d_en = 1'b0, d_sub = 1'b0;
    logic [1:0]  d_md = 2'b00;
    logic [63:0] d_a = '0, d_b = '0, d_r;
    logic        d_ovf, d_unf, d_inx, d_inv;

    fp_addsub i_fp_addsub (
        .clk(clk), .rst_n(rst_n), .en(d_en), .a_i(d_a), .b_i(d_b),
        .sub_i(d_sub), .rmode_i(d_md), .sum_o(d_r), .overflow_o(d_ovf),
        .underflow_o(d_unf), .inexact_o(d_inx), .invalid_o(d_inv)
    );

    // Narrow instance: 3-bit exponent (bias 3), 3-bit fraction.
    logic        s_en = 1'b0, s_sub = 1'b0;
    logic [1:0]  s_md = 2'b00;
    logic [6:0]  s_a = '0, s_b = '0, s_r;
    logic        s_ovf, s_unf, s_inx, s_inv;

    fp_addsub #(.EXP_W(3), .FRAC_W(3)) i_fp_addsub_mini (
        .clk(clk), .rst_n(rst_n), .en(s_en), .a_i(s_a), .b_i(s_b),
        .sub_i(s_sub), .rmode_i(s_md), .sum_o(s_r), .overflow_o(s_ovf),
        .underflow_o(s_unf), .inexact_o(s_inx), .invalid_o(s_inv)
    );

    // One comparison; flags ordered {overflow, underflow, inexact, invalid}.
    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp_v,
                       input logic [3:0] gf, input logic [3:0] ef);
        checks++;
        if (got !== exp_v || gf !== ef) begin
            errors++;
            $display("FAIL %s: got %h flags %b, expected %h flags %b", tag, got, gf, exp_v, ef);
        end
    endtask

    // Exact-sum model of the narrow format, rounded by the requirements.
    function automatic void model(input logic [6:0] a, input logic [6:0] b,
                                  input logic sub, input logic [1:0] md,
                                  output logic [6:0] r, output logic [3:0] fl,
                                  output string tag);
        int ea, eb, fa, fb, ma, mb, va, vb, s, m, p, sh, keep, rem, half, ex;
        logic sa, sbe, sg, inc, toinf, nan_a, nan_b, inf_a, inf_b;
        sa = a[6]; sbe = b[6] ^ sub;
        ea = a[5:3]; fa = a[2:0]; eb = b[5:3]; fb = b[2:0];
        nan_a = (ea == 7) && (fa != 0); nan_b = (eb == 7) && (fb != 0);
        inf_a = (ea == 7) && (fa == 0); inf_b = (eb == 7) && (fb == 0);
        fl = 4'b0000;
        tag = "R1 R2 R3";
        if (nan_a || nan_b || (inf_a && inf_b && sa != sbe)) begin
            r = 7'b0_111_100; fl = 4'b0001; tag = "R7"; return;
        end
        if (inf_a) begin r = {sa, 6'b111_000}; tag = "R8"; return; end
        if (inf_b) begin r = {sbe, 6'b111_000}; tag = "R8"; return; end
        ma = ((ea == 0) ? fa : fa + 8) << (((ea == 0) ? 1 : ea) - 1);
        mb = ((eb == 0) ? fb : fb + 8) << (((eb == 0) ? 1 : eb) - 1);
        va = sa ? -ma : ma;
        vb = sbe ? -mb : mb;
        s = va + vb;
        if (s == 0) begin
            sg = (sa == sbe) ? sa : (md == 2'b11);
            r = {sg, 6'b0}; tag = "R5"; return;
        end
        sg = (s < 0);
        m = sg ? -s : s;
        if (ea - eb > 5 || eb - ea > 5) tag = "R4 R3";
        if (m < 8) begin
            r = {sg, 3'b000, 3'(m)}; fl = 4'b0100; tag = "R10"; return;
        end
        if (m < 16) begin
            r = {sg, 3'b001, 3'(m - 8)}; return;
        end
        p = 0;
        for (int i = 0; i < 31; i++) if (m >= (1 << i)) p = i;
        sh = p - 3;
        keep = m >> sh;
        rem = m - (keep << sh);
        half = 1 << (sh - 1);
        case (md)
            2'b00: inc = (rem > half) || (rem == half && (keep % 2) == 1);
            2'b01: inc = 1'b0;
            2'b10: inc = (rem != 0) && !sg;
            default: inc = (rem != 0) && sg;
        endcase
        keep = keep + int'(inc);
        if (keep == 16) begin keep = 8; sh = sh + 1; end
        ex = sh + 1;
        if (ex >= 7) begin
            toinf = (md == 2'b00) || (md == 2'b10 && !sg) || (md == 2'b11 && sg);
            r = toinf ? {sg, 6'b111_000} : {sg, 6'b110_111};
            fl = 4'b1010; tag = "R6"; return;
        end
        r = {sg, 3'(ex), 3'(keep - 8)};
        if (rem != 0) begin fl = 4'b0010; tag = {tag, " R9"}; end
    endfunction

    // Directed 64-bit vector: drive, wait one edge, compare.
    task automatic d64(input string tag, input logic [63:0] a, input logic [63:0] b,
                       input logic sub, input logic [1:0] md,
                       input logic [63:0] er, input logic [3:0] ef);
        @(negedge clk);
        d_a = a; d_b = b; d_sub = sub; d_md = md; d_en = 1'b1;
        @(negedge clk);
        d_en = 1'b0;
        chk(tag, d_r, er, {d_ovf, d_unf, d_inx, d_inv}, ef);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: run did not finish, got hang expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [6:0] er, last_r;
        logic [3:0] ef, last_f;
        string etag;
        bit pend;

        repeat (3) @(negedge clk);
        // R12: reset clears result and flags
        chk("R12 reset 64", d_r, 64'h0, {d_ovf, d_unf, d_inx, d_inv}, 4'b0);
        chk("R12 reset mini", {57'h0, s_r}, 64'h0, {s_ovf, s_unf, s_inx, s_inv}, 4'b0);
        rst_n = 1'b1;

        d64("R1 1+2", 64'h3FF0000000000000, 64'h4000000000000000, 1'b0, 2'b00, 64'h4008000000000000, 4'b0000);
        d64("R1 74.5+1", 64'h4052A00000000000, 64'h3FF0000000000000, 1'b0, 2'b00, 64'h4052E00000000000, 4'b0000);
        d64("R2 3-1", 64'h4008000000000000, 64'h3FF0000000000000, 1'b1, 2'b00, 64'h4000000000000000, 4'b0000);
        d64("R5 1-1 nearest", 64'h3FF0000000000000, 64'h3FF0000000000000, 1'b1, 2'b00, 64'h0, 4'b0000);
        d64("R5 1-1 toward -inf", 64'h3FF0000000000000, 64'h3FF0000000000000, 1'b1, 2'b11, 64'h8000000000000000, 4'b0000);
        d64("R4 R9 1+tiny up", 64'h3FF0000000000000, 64'h3C30000000000000, 1'b0, 2'b10, 64'h3FF0000000000001, 4'b0010);
        d64("R4 R9 1+tiny nearest", 64'h3FF0000000000000, 64'h3C30000000000000, 1'b0, 2'b00, 64'h3FF0000000000000, 4'b0010);
        d64("R6 max+max nearest", 64'h7FEFFFFFFFFFFFFF, 64'h7FEFFFFFFFFFFFFF, 1'b0, 2'b00, 64'h7FF0000000000000, 4'b1010);
        d64("R6 max+max to zero", 64'h7FEFFFFFFFFFFFFF, 64'h7FEFFFFFFFFFFFFF, 1'b0, 2'b01, 64'h7FEFFFFFFFFFFFFF, 4'b1010);
        d64("R7 inf-inf", 64'h7FF0000000000000, 64'h7FF0000000000000, 1'b1, 2'b00, 64'h7FF8000000000000, 4'b0001);
        d64("R10 subnormal sum", 64'h1, 64'h1, 1'b0, 2'b00, 64'h2, 4'b0100);

        // Exhaustive sweep of the narrow format, one vector per cycle.
        pend = 1'b0;
        for (int md = 0; md < 4; md++) begin
            for (int sb = 0; sb < 2; sb++) begin
                for (int a = 0; a < 128; a++) begin
                    for (int b = 0; b < 128; b++) begin
                        @(negedge clk);
                        if (pend) chk(etag, {57'h0, s_r}, {57'h0, er},
                                      {s_ovf, s_unf, s_inx, s_inv}, ef);
                        s_a = 7'(a); s_b = 7'(b); s_sub = 1'(sb); s_md = 2'(md);
                        s_en = 1'b1;
                        model(7'(a), 7'(b), 1'(sb), 2'(md), er, ef, etag);
                        pend = 1'b1;
                    end
                end
            end
        end
        @(negedge clk);
        chk(etag, {57'h0, s_r}, {57'h0, er}, {s_ovf, s_unf, s_inx, s_inv}, ef);
        last_r = er; last_f = ef;

        // R11: enable low holds the previous result despite new inputs
        s_en = 1'b0; s_a = 7'h18; s_b = 7'h18; s_sub = 1'b0; s_md = 2'b00;
        @(negedge clk);
        @(negedge clk);
        chk("R11 hold", {57'h0, s_r}, {57'h0, last_r}, {s_ovf, s_unf, s_inx, s_inv}, last_f);

        // R11: enable high captures 1.0+1.0 = 2.0 after one edge
        s_en = 1'b1;
        @(negedge clk);
        s_en = 1'b0;
        chk("R11 capture", {57'h0, s_r}, 64'h20, {s_ovf, s_unf, s_inx, s_inv}, 4'b0);

        // R12: synchronous reset with enable high still clears
        s_en = 1'b1; s_a = 7'h7F; rst_n = 1'b0;
        @(negedge clk);
        chk("R12 reset in run", {57'h0, s_r}, 64'h0, {s_ovf, s_unf, s_inx, s_inv}, 4'b0);
        s_en = 1'b0; rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule